// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

This block counts events on two count inputs of opposite edge sensitivity and presents the count as ten one-hot decoded lines and an active-low carry. The count lives in a five-bit twisted-ring register. The ring walks through ten legal codes. Each code is decoded by looking at a pair of neighbouring bits. Because only one bit of the ring changes per step, the decode does not glitch.

Each count input is also the enable of the other. A rising edge on `rise_cnt_i` counts only while `fall_cnt_i` is low. A falling edge on `fall_cnt_i` counts only while `rise_cnt_i` is high. Both inputs are brought into the system clock domain by synchronizers, and edges are found by comparing each synchronized level with its value one cycle earlier.

A master clear forces state zero at once, with no clock needed. The clear is released in step with the clock. One middle stage of the ring has modified feedback, so any code outside the legal ten is flushed out of the ring as it advances.

Top module: `johnson_decade_counter`

## Requirements
- R1: While `rst_n` is low or `clear_i` is high, `dec_o` equals 10'b0000000001 (bit 0 high) and `carry_n_o` is 1. Raising `clear_i` takes effect with no clock edge. This holds with the default `INIT_CODE` of zero.
- R2: A 0-to-1 change of `rise_cnt_i` while `fall_cnt_i` is low advances the count by one.
- R3: A 1-to-0 change of `fall_cnt_i` while `rise_cnt_i` is high advances the count by one.
- R4: The count holds in all of these cases: a rising `rise_cnt_i` while `fall_cnt_i` is high, a falling `fall_cnt_i` while `rise_cnt_i` is low, a falling `rise_cnt_i`, a rising `fall_cnt_i`, or no change on either input.
- R5: When both qualifying edges land in the same sampled cycle, the count advances by exactly one.
- R6: In state k (0..9), `dec_o[k]` is the only high bit. Advances go 0,1,...,9 and then back to 0.
- R7: `carry_n_o` is 0 in states 5 through 9 and 1 in states 0 through 4.
- R8: An input change applied between clock edges reaches the outputs right after the third rising clock edge that follows it.
- R9: After `clear_i` falls, the first two rising clock edges cannot advance the count. The third edge can.
- R10: Take a ring that starts from any of the 32 five-bit codes, given through `INIT_CODE` while in reset. After at most 11 advances, `dec_o` is one-hot at some index k, with `carry_n_o` equal to 0 exactly when k is 5 or more. The next advance moves the one-hot bit to (k+1) mod 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, assumed released synchronously |
| clear_i | input | 1 | Active-high master clear; asynchronous assert, synchronous release |
| rise_cnt_i | input | 1 | Count input, rising-edge sensitive; also enables `fall_cnt_i` |
| fall_cnt_i | input | 1 | Count input, falling-edge sensitive; its low level enables `rise_cnt_i` |
| dec_o | output | 10 | One-hot decoded count, bit k high in state k |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
A corrupted ring code shows up at the ports at once. It appears as two or zero decode lines high, or as a carry that disagrees with which line is high, and it also breaks the expected next index on the following advance. The bench compares every cycle against a behavioural modulo-ten model. Any gating or latency error therefore shows up as a wrong index within one cycle of the edge it mishandled. Thirty-two extra instances, one started from each possible code, show that every illegal code is flushed within eleven advances. That check fails on a plain twisted ring, whose illegal loops never end.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  localparam int RING_W    = 5;
  localparam int DEC_W     = 2 * RING_W;
  localparam int FIX_STAGE = 2;

  typedef logic [RING_W-1:0] ring_t;
  typedef logic [DEC_W-1:0]  dec_t;

  // legal ring codes have at most one boundary between neighbouring bits
  function automatic logic ring_is_legal(ring_t code);
    int edges;
    edges = 0;
    for (int i = 0; i < RING_W - 1; i++) begin
      if (code[i] != code[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction
endpackage

// File: rtl/jdc_sync_bit.sv
module jdc_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/jdc_reset_sync.sv
module jdc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic ring_rst_n
);
  logic              arst_n;
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  assign arst_n = rst_n & ~clear_i;

  always_comb begin
    rs_d = {rs_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= '0;
    else         rs_q <= rs_d;
  end

  assign ring_rst_n = rs_q[STAGES-1];
endmodule

// File: rtl/jdc_edge_qual.sv
module jdc_edge_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_cnt_i,
  input  logic fall_cnt_i,
  output logic adv_o
);
  localparam int NUM_IN = 2;
  localparam int IDX_R  = 0;
  localparam int IDX_F  = 1;

  logic [NUM_IN-1:0] raw;
  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:0] prev_q;
  logic              rise_seen;
  logic              fall_seen;

  assign raw = {fall_cnt_i, rise_cnt_i};

  for (genvar k = 0; k < NUM_IN; k++) begin : g_sync
    jdc_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw[k]),
      .q_o  (lvl[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  always_comb begin
    rise_seen = lvl[IDX_R] & ~prev_q[IDX_R] & ~lvl[IDX_F];
    fall_seen = prev_q[IDX_F] & ~lvl[IDX_F] & lvl[IDX_R];
    adv_o     = rise_seen | fall_seen;
  end
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
#(
  parameter ring_t INIT_CODE = '0
) (
  input  logic  clk,
  input  logic  arst_n,
  input  logic  adv_i,
  output ring_t state_o
);
  ring_t ring_q;
  ring_t ring_d;

  // next code: shift up, inverted feedback; one stage refuses isolated ones
  for (genvar i = 0; i < RING_W; i++) begin : g_next
    if (i == 0) begin : g_fb
      assign ring_d[i] = ~ring_q[RING_W-1];
    end else if (i == FIX_STAGE) begin : g_fix
      assign ring_d[i] = ring_q[i-1] & (ring_q[i-2] | ring_q[i]);
    end else begin : g_shift
      assign ring_d[i] = ring_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    ring_q <= INIT_CODE;
    else if (adv_i) ring_q <= ring_d;
  end

  assign state_o = ring_q;

  // checker-side counter of advances spent in an illegal code
  logic [3:0] bad_adv_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                   bad_adv_q <= '0;
    else if (ring_is_legal(ring_q)) bad_adv_q <= '0;
    else if (adv_i)                bad_adv_q <= bad_adv_q + 4'd1;
  end

  a_r10_recover_within_eleven: assert property (@(posedge clk) disable iff (!arst_n)
    !ring_is_legal(ring_q) |-> (bad_adv_q < 4'd11));

  a_r4_hold_without_advance: assert property (@(posedge clk) disable iff (!arst_n)
    !adv_i |=> $stable(ring_q));
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
  import jdc_pkg::*;
(
  input  ring_t state_i,
  output dec_t  dec_o,
  output logic  carry_n_o
);
  localparam int HALF = RING_W;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    if (i == 0) begin : g_wrap
      assign dec_o[i]        = ~state_i[HALF-1] & ~state_i[0];
      assign dec_o[i + HALF] =  state_i[HALF-1] &  state_i[0];
    end else begin : g_mid
      assign dec_o[i]        =  state_i[i-1] & ~state_i[i];
      assign dec_o[i + HALF] = ~state_i[i-1] &  state_i[i];
    end
  end

  assign carry_n_o = ~state_i[HALF-1];
endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter
  import jdc_pkg::*;
#(
  parameter ring_t INIT_CODE   = '0,
  parameter int    SYNC_STAGES = 2,
  parameter int    RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       rise_cnt_i,
  input  logic       fall_cnt_i,
  output logic [9:0] dec_o,
  output logic       carry_n_o
);
  logic  ring_rst_n;
  logic  adv;
  ring_t state;
  dec_t  dec;

  jdc_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .ring_rst_n(ring_rst_n)
  );

  jdc_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_cnt_i(rise_cnt_i),
    .fall_cnt_i(fall_cnt_i),
    .adv_o     (adv)
  );

  jdc_ring #(.INIT_CODE(INIT_CODE)) u_ring (
    .clk    (clk),
    .arst_n (ring_rst_n),
    .adv_i  (adv),
    .state_o(state)
  );

  jdc_decode u_dec (
    .state_i  (state),
    .dec_o    (dec),
    .carry_n_o(carry_n_o)
  );

  assign dec_o = dec;

  a_r6_onehot_when_legal: assert property (@(posedge clk) disable iff (!ring_rst_n)
    ring_is_legal(state) |-> ($countones(dec_o) == 1));

  a_r7_carry_tracks_upper: assert property (@(posedge clk) disable iff (!ring_rst_n)
    ring_is_legal(state) |-> (carry_n_o == ~(|dec_o[9:5])));

  if (INIT_CODE == '0) begin : g_clr_chk
    a_r1_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |-> (dec_o == 10'b0000000001 && carry_n_o));
  end
endmodule

// File: tb/johnson_decade_counter_tb.sv
`timescale 1ns/1ps
module johnson_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr;
  logic       cp_r;
  logic       cp_f;
  logic [9:0] dec;
  logic       carry_n;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  johnson_decade_counter u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clr),
    .rise_cnt_i(cp_r), .fall_cnt_i(cp_f),
    .dec_o(dec), .carry_n_o(carry_n)
  );

  // one instance per starting code for the recovery check
  logic       fx_r;
  logic [9:0] fx_dec   [32];
  logic       fx_carry [32];
  for (genvar g = 0; g < 32; g++) begin : g_fx
    johnson_decade_counter #(.INIT_CODE(5'(g))) u_fx (
      .clk(clk), .rst_n(rst_n), .clear_i(1'b0),
      .rise_cnt_i(fx_r), .fall_cnt_i(1'b0),
      .dec_o(fx_dec[g]), .carry_n_o(fx_carry[g])
    );
  end

  // behavioural model state
  int m_cnt, m_hold;
  int r1, r2, rp, f1, f2, fp;

  task automatic check(input string tag);
    logic [9:0] exp_d;
    logic       exp_c;
    exp_d = 10'(1) << m_cnt;
    exp_c = (m_cnt < 5);
    tests++;
    if (dec !== exp_d) begin
      fails++;
      $display("FAIL %s dec_o act=%b exp=%b", tag, dec, exp_d);
    end
    tests++;
    if (carry_n !== exp_c) begin
      fails++;
      $display("FAIL R7 carry_n_o act=%b exp=%b (%s)", carry_n, exp_c, tag);
    end
  endtask

  task automatic cyc(input logic a, input logic b, input logic c, input string tag);
    bit adv;
    @(negedge clk);
    cp_r = a; cp_f = b; clr = c;
    #1;
    if (c) begin
      m_cnt = 0; m_hold = 2;
      check("R1");
    end
    @(posedge clk);
    adv = (r2 == 1 && rp == 0 && f2 == 0) || (fp == 1 && f2 == 0 && r2 == 1);
    if (c) begin
      m_cnt = 0; m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold--;
    end else if (adv) begin
      m_cnt = (m_cnt + 1) % 10;
    end
    rp = r2; r2 = r1; r1 = a;
    fp = f2; f2 = f1; f1 = b;
    #1;
    check(tag);
  endtask

  task automatic hold_n(input logic a, input logic b, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(a, b, 1'b0, tag);
  endtask

  task automatic fx_pulse();
    @(negedge clk); fx_r = 1'b1;
    repeat (4) @(negedge clk);
    fx_r = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int idx  [32];
    bit okay [32];
    rst_n = 0; clr = 0; cp_r = 0; cp_f = 0; fx_r = 0;
    repeat (3) @(negedge clk);
    m_cnt = 0;
    check("R1");
    @(negedge clk);
    rst_n = 1;
    m_hold = 2; r1 = 0; r2 = 0; rp = 0; f1 = 0; f2 = 0; fp = 0;

    hold_n(0, 0, 4, "R1");
    // R8: rise applied, visible after third edge (model checks every cycle)
    hold_n(1, 0, 5, "R8");
    hold_n(0, 0, 4, "R2");
    hold_n(1, 0, 4, "R2");
    // R4: gated and opposite edges
    hold_n(1, 1, 4, "R4");
    hold_n(0, 1, 4, "R4");
    hold_n(1, 1, 4, "R4");
    hold_n(0, 1, 4, "R4");
    hold_n(0, 0, 4, "R4");
    hold_n(0, 0, 4, "R4");
    // R3: falling edge with rise input high
    hold_n(1, 0, 4, "R2");
    hold_n(1, 1, 4, "R3");
    hold_n(1, 0, 4, "R3");
    // R5: coincident qualifying edges
    hold_n(0, 1, 4, "R5");
    hold_n(1, 0, 4, "R5");
    // R6/R7: full wrap
    for (int p = 0; p < 12; p++) begin
      hold_n(0, 0, 4, "R6");
      hold_n(1, 0, 4, "R6");
    end
    // R9: clear in mid count, then an edge right at release
    hold_n(0, 0, 4, "R9");
    cyc(1, 0, 0, "R9");
    cyc(1, 0, 1, "R9");
    cyc(0, 0, 1, "R9");
    cyc(0, 0, 0, "R9");
    cyc(1, 0, 0, "R9");
    hold_n(1, 0, 5, "R9");
    hold_n(0, 0, 2, "R9");
    cyc(0, 0, 1, "R9");
    cyc(1, 0, 0, "R9");
    hold_n(1, 0, 5, "R9");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 63) == 0), "R4");
    end

    // R10: recovery from every starting code
    for (int p = 0; p < 11; p++) fx_pulse();
    for (int g = 0; g < 32; g++) begin
      idx[g] = -1;
      for (int k = 0; k < 10; k++) if (fx_dec[g][k]) idx[g] = k;
      okay[g] = ($countones(fx_dec[g]) == 1) && (idx[g] >= 0) &&
                (fx_carry[g] == (idx[g] < 5));
      tests++;
      if (!okay[g]) begin
        fails++;
        $display("FAIL R10 code=%0d dec_o act=%b carry=%b exp=one-hot", g, fx_dec[g], fx_carry[g]);
      end
    end
    fx_pulse();
    for (int g = 0; g < 32; g++) begin
      logic [9:0] e;
      e = okay[g] ? (10'(1) << ((idx[g] + 1) % 10)) : 10'b0;
      tests++;
      if (fx_dec[g] !== e) begin
        fails++;
        $display("FAIL R10 code=%0d next dec_o act=%b exp=%b", g, fx_dec[g], e);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule